// File: doc/BRIEF.md
# General-Purpose Register File with Stack/Zero Aliasing

This block holds the integer architectural state of a 64-bit core: thirty-one general registers plus one stack-pointer register, reached through a 5-bit index. Index 31 is overloaded. Each access carries its own select bit. When the bit is set, index 31 reaches the stack-pointer register. When it is clear, index 31 acts as a zero source and a write sink.

There is one write port and two independent read ports. The write port takes either a full 64-bit value or a 32-bit value; a 32-bit value clears the upper half of its destination. Each read port extracts the low 8, 16, 32 or 64 bits and widens them to 64 bits, with either zero fill or sign fill. A separate link strobe loads register 30 with a supplied next-PC value, so a call can save its return address in the same cycle that another register is written.

Writes land on the rising clock edge, and reset is synchronous and active low. Reads are combinational, so a read that targets the register being written in the same cycle returns the value from before the write.

Top module: `gpr_file`

## Requirements
- R1: While `rst_n` is low at a rising edge, all thirty-one general registers and the stack pointer become zero. Every index then reads zero with either select value.
- R2: A 64-bit write (`wr_en`=1, `wr_narrow`=0) to index 0..30 stores all 64 bits at the rising edge. A read of that index in the same cycle as the write returns the previous value.
- R3: A 32-bit write (`wr_narrow`=1) stores `wr_data[31:0]` in bits 31:0 of the destination and zeros bits 63:32, whatever `wr_data[63:32]` holds.
- R4: A read of index 31 with its select bit at 0 returns zero on all 64 bits. This holds for every size and sign mode, and after any earlier write aimed at index 31.
- R5: A write to index 31 with `wr_sp_sel`=0 is discarded. No general register and not the stack pointer changes.
- R6: With the select bit at 1, writes and reads of index 31 reach a dedicated stack-pointer register, and the same width rules (R2, R3) apply to it.
- R7: `rd_size_*` selects the extracted field: 0 gives bits 7:0, 1 gives bits 15:0, 2 gives bits 31:0 and 3 gives all 64 bits. With `rd_signed_*`=1, the bits above the field copy the field's top bit. With `rd_signed_*`=0, those bits are zero.
- R8: When `link_save` is high at a rising edge, register 30 takes the full 64-bit `next_pc`.
- R9: If `link_save` and a write to index 30 happen in the same cycle, register 30 takes `next_pc`. A write to any other index in that cycle still takes effect.
- R10: The two read ports are independent. Each uses its own index, select, size and sign inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write destination index |
| wr_sp_sel | input | 1 | 1: index 31 is the stack pointer for this write; 0: index 31 is the zero sink |
| wr_narrow | input | 1 | 1: 32-bit write with upper half cleared; 0: 64-bit write |
| wr_data | input | 64 | Write data |
| link_save | input | 1 | Load register 30 from next_pc |
| next_pc | input | 64 | Return address used by link_save |
| rd_idx_a | input | 5 | Port A read index |
| rd_sp_sel_a | input | 1 | Port A index-31 select |
| rd_size_a | input | 2 | Port A field size code (0=8, 1=16, 2=32, 3=64 bits) |
| rd_signed_a | input | 1 | Port A sign fill when 1, zero fill when 0 |
| rd_data_a | output | 64 | Port A read result |
| rd_idx_b | input | 5 | Port B read index |
| rd_sp_sel_b | input | 1 | Port B index-31 select |
| rd_size_b | input | 2 | Port B field size code |
| rd_signed_b | input | 1 | Port B sign fill when 1, zero fill when 0 |
| rd_data_b | output | 64 | Port B read result |

## Verification
The assertions check the following on every cycle:
- the zero result of index 31 when its select bit is clear;
- the fill bits above 8-bit fields;
- that a discarded index-31 write leaves the stored state untouched;
- the cleared upper half after 32-bit writes;
- the arrival of `next_pc` in register 30, including when it collides with a normal write.

Only the bench scenarios can show the following:
- that every index holds its own value, which the bench proves by sweeping all indices, sizes and sign modes on both ports against a model;
- that a same-cycle read returns the old value;
- that reset clears every register.

// File: rtl/gpr_pkg.sv
// Package: shared widths and field-size codes for the register file.
// Assumes a 64-bit datapath with a 32-entry index space.
package gpr_pkg;
    localparam int DATA_W   = 64;
    localparam int NUM_IDX  = 32;
    localparam int IDX_W    = $clog2(NUM_IDX);
    localparam int NUM_GPR  = NUM_IDX - 1;   // last index is the alias slot
    localparam int LINK_IDX = 30;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_FULL = 2'd3
    } fld_size_e;
endpackage

// File: rtl/gpr_store.sv
// Module: gpr_store
// Holds the general registers and the stack pointer and applies the write rules.
// Assumes: the alias index is NUM_GPR; link_save overrides a same-cycle write
// to LINK; a discarded alias write touches no state.
module gpr_store
    import gpr_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NREG = NUM_GPR,
    parameter int IW   = IDX_W,
    parameter int LINK = LINK_IDX
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic                  wr_sp_sel,
    input  logic                  wr_narrow,
    input  logic [W-1:0]          wr_data,
    input  logic                  link_save,
    input  logic [W-1:0]          next_pc,
    output logic [NREG-1:0][W-1:0] regs_q,
    output logic [W-1:0]          sp_q
);
    localparam int HALF = W / 2;
    localparam logic [IW-1:0] ALIAS = IW'(NREG);

    logic [W-1:0] wval;

    // Apply the write width: a narrow write clears the upper half.
    always_comb begin
        wval = wr_narrow ? {{HALF{1'b0}}, wr_data[HALF-1:0]} : wr_data;
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic hit;
            assign hit = wr_en && (wr_idx == IW'(g));
            if (g == LINK) begin : g_link
                // Register with link-save priority over the normal write.
                always_ff @(posedge clk) begin
                    if (!rst_n)         regs_q[g] <= '0;
                    else if (link_save) regs_q[g] <= next_pc;
                    else if (hit)       regs_q[g] <= wval;
                end
            end else begin : g_plain
                // Plain register: load on an index match.
                always_ff @(posedge clk) begin
                    if (!rst_n)   regs_q[g] <= '0;
                    else if (hit) regs_q[g] <= wval;
                end
            end
        end
    endgenerate

    // Stack pointer: written only when the alias index selects it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      sp_q <= '0;
        else if (wr_en && wr_idx == ALIAS && wr_sp_sel)  sp_q <= wval;
    end

    // R5
    alias_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == ALIAS && !wr_sp_sel && !link_save)
        |=> ($stable(regs_q) && $stable(sp_q)));

    // R3
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_narrow && wr_idx < ALIAS && !(link_save && wr_idx == IW'(LINK)))
        |=> (regs_q[$past(wr_idx)][W-1:HALF] == '0));

    // R6
    sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == ALIAS && wr_sp_sel && !wr_narrow)
        |=> (sp_q == $past(wr_data)));

    // R8
    link_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_save |=> (regs_q[LINK] == $past(next_pc)));

    // R9
    link_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_save && wr_en && wr_idx == IW'(LINK) && wr_data != next_pc)
        |=> (regs_q[LINK] != $past(wr_data)));
endmodule

// File: rtl/gpr_read_port.sv
// Module: gpr_read_port
// One combinational read port. It resolves the alias index to the stack
// pointer or to zero, extracts a field and widens it with zero or sign fill.
// Assumes: the stored state arrives as a packed bus from gpr_store.
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NREG = NUM_GPR,
    parameter int IW   = IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0][W-1:0] regs_q,
    input  logic [W-1:0]           sp_q,
    input  logic [IW-1:0]          idx,
    input  logic                   sp_sel,
    input  fld_size_e              size,
    input  logic                   sgn,
    output logic [W-1:0]           data
);
    localparam int HALF = W / 2;
    localparam int QTR  = W / 4;
    localparam int OCT  = W / 8;
    localparam logic [IW-1:0] ALIAS = IW'(NREG);

    logic [NREG:0][W-1:0] view;
    logic [W-1:0]         raw;

    // Build the full index view with the alias slot resolved.
    always_comb begin
        view = {(sp_sel ? sp_q : {W{1'b0}}), regs_q};
        raw  = view[idx];
    end

    // Extract the requested field and widen it.
    always_comb begin
        unique case (size)
            SZ_BYTE: data = {{(W-OCT){sgn & raw[OCT-1]}},  raw[OCT-1:0]};
            SZ_HALF: data = {{(W-QTR){sgn & raw[QTR-1]}},  raw[QTR-1:0]};
            SZ_WORD: data = {{(W-HALF){sgn & raw[HALF-1]}}, raw[HALF-1:0]};
            default: data = raw;
        endcase
    end

    // R4
    zero_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == ALIAS && !sp_sel) |-> (data == '0));

    // R7
    byte_sfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE && sgn) |->
        ($countones(data[W-1:OCT-1]) == 0 || $countones(data[W-1:OCT-1]) == W-OCT+1));

    // R7
    byte_zfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE && !sgn) |-> (data[W-1:OCT] == '0));
endmodule

// File: rtl/gpr_file.sv
// Module: gpr_file (top)
// Register file with one write port, two read ports and a link-save strobe.
// Index 31 is the stack pointer or a zero slot, chosen per access.
// Assumes: synchronous active-low reset; reads are combinational.
module gpr_file
    import gpr_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_sp_sel,
    input  logic          wr_narrow,
    input  logic [W-1:0]  wr_data,
    input  logic          link_save,
    input  logic [W-1:0]  next_pc,
    input  logic [IW-1:0] rd_idx_a,
    input  logic          rd_sp_sel_a,
    input  logic [1:0]    rd_size_a,
    input  logic          rd_signed_a,
    output logic [W-1:0]  rd_data_a,
    input  logic [IW-1:0] rd_idx_b,
    input  logic          rd_sp_sel_b,
    input  logic [1:0]    rd_size_b,
    input  logic          rd_signed_b,
    output logic [W-1:0]  rd_data_b
);
    localparam int NREG   = (1 << IW) - 1;
    localparam int NPORTS = 2;

    logic [NREG-1:0][W-1:0] regs_q;
    logic [W-1:0]           sp_q;

    logic [NPORTS-1:0][IW-1:0] p_idx;
    logic [NPORTS-1:0]         p_sel;
    logic [NPORTS-1:0][1:0]    p_size;
    logic [NPORTS-1:0]         p_sgn;
    logic [NPORTS-1:0][W-1:0]  p_data;

    // Gather the read-port inputs and scatter the results.
    always_comb begin
        p_idx  = {rd_idx_b, rd_idx_a};
        p_sel  = {rd_sp_sel_b, rd_sp_sel_a};
        p_size = {rd_size_b, rd_size_a};
        p_sgn  = {rd_signed_b, rd_signed_a};
        rd_data_a = p_data[0];
        rd_data_b = p_data[1];
    end

    gpr_store #(.W(W), .NREG(NREG), .IW(IW), .LINK(LINK_IDX)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp_sel(wr_sp_sel),
        .wr_narrow(wr_narrow), .wr_data(wr_data),
        .link_save(link_save), .next_pc(next_pc),
        .regs_q(regs_q), .sp_q(sp_q)
    );

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_rd
            gpr_read_port #(.W(W), .NREG(NREG), .IW(IW)) u_rd (
                .clk(clk), .rst_n(rst_n),
                .regs_q(regs_q), .sp_q(sp_q),
                .idx(p_idx[p]), .sp_sel(p_sel[p]),
                .size(fld_size_e'(p_size[p])), .sgn(p_sgn[p]),
                .data(p_data[p])
            );
        end
    endgenerate
endmodule

// File: tb/tb_gpr_file.sv
// Bench for gpr_file: a model from the requirements plus index/size/sign sweeps.
module tb_gpr_file;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, wr_sp_sel = 0, wr_narrow = 0, link_save = 0;
    logic [4:0]  wr_idx = 0;
    logic [63:0] wr_data = 0, next_pc = 0;
    logic [4:0]  rd_idx_a = 0, rd_idx_b = 0;
    logic        rd_sp_sel_a = 0, rd_sp_sel_b = 0, rd_signed_a = 0, rd_signed_b = 0;
    logic [1:0]  rd_size_a = 0, rd_size_b = 0;
    logic [63:0] rd_data_a, rd_data_b;

    int checks = 0, errors = 0;
    logic [63:0] m_reg [31];
    logic [63:0] m_sp;

    always #(CLK_P/2) clk = ~clk;

    gpr_file dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sp_sel(wr_sp_sel), .wr_narrow(wr_narrow), .wr_data(wr_data),
        .link_save(link_save), .next_pc(next_pc),
        .rd_idx_a(rd_idx_a), .rd_sp_sel_a(rd_sp_sel_a), .rd_size_a(rd_size_a),
        .rd_signed_a(rd_signed_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_sp_sel_b(rd_sp_sel_b), .rd_size_b(rd_size_b),
        .rd_signed_b(rd_signed_b), .rd_data_b(rd_data_b)
    );

    function automatic logic [63:0] model_val(input int idx, input logic sel);
        if (idx == 31) return sel ? m_sp : 64'd0;
        return m_reg[idx];
    endfunction

    function automatic logic [63:0] widen(input logic [63:0] v, input int sz, input logic sg);
        int nb = 8 << sz;
        logic [63:0] mask = (nb == 64) ? ~64'd0 : ((64'd1 << nb) - 64'd1);
        logic [63:0] r = v & mask;
        if (sg && nb < 64 && r[nb-1]) r = r | ~mask;
        return r;
    endfunction

    function automatic logic [63:0] pat(input int i, input int salt);
        return (64'h9E3779B97F4A7C15 * 64'(i + 1 + salt)) ^ (64'(salt) << 40);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sweep both ports over every index, select, size and sign.
    task automatic verify_all(input string req);
        for (int i = 0; i < 32; i++)
            for (int s = 0; s < 2; s++)
                for (int z = 0; z < 4; z++)
                    for (int g = 0; g < 2; g++) begin
                        rd_idx_a = 5'(i);      rd_sp_sel_a = s[0];
                        rd_size_a = 2'(z);     rd_signed_a = g[0];
                        rd_idx_b = 5'(31 - i); rd_sp_sel_b = ~s[0];
                        rd_size_b = 2'(3 - z); rd_signed_b = ~g[0];
                        #1;
                        check({req, " R7 portA"}, rd_data_a,
                              widen(model_val(i, s[0]), z, g[0]));
                        check({req, " R10 portB"}, rd_data_b,
                              widen(model_val(31 - i, ~s[0]), 3 - z, ~g[0]));
                    end
    endtask

    // One clocked operation; the model follows the requirements.
    task automatic op(input logic en, input int idx, input logic sel, input logic nar,
                      input logic [63:0] d, input logic ls, input logic [63:0] pc);
        logic [63:0] v;
        @(negedge clk);
        wr_en = en; wr_idx = 5'(idx); wr_sp_sel = sel; wr_narrow = nar;
        wr_data = d; link_save = ls; next_pc = pc;
        @(negedge clk);
        wr_en = 0; link_save = 0;
        v = nar ? {32'd0, d[31:0]} : d;
        if (en && !(idx == 31 && !sel)) begin
            if (idx == 31) m_sp = v; else m_reg[idx] = v;
        end
        if (ls) m_reg[30] = pc;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 31; i++) m_reg[i] = 0;
        m_sp = 0;
        // Preload through the write port before reset so that R1 proves clearing.
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 31; i++) op(1, i, 0, 0, ~64'd0, 0, 0);
        op(1, 31, 1, 0, ~64'd0, 0, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        for (int i = 0; i < 31; i++) m_reg[i] = 0;
        m_sp = 0;
        verify_all("R1 reset");

        // R2: full writes with varied patterns, then a full sweep.
        for (int i = 0; i < 31; i++) op(1, i, 0, 0, pat(i, 0), 0, 0);
        op(1, 31, 1, 0, pat(31, 0), 0, 0);
        verify_all("R2 full writes");

        // R2: a same-cycle read returns the old value.
        @(negedge clk);
        wr_en = 1; wr_idx = 5; wr_sp_sel = 0; wr_narrow = 0; wr_data = 64'h1234_5678_9ABC_DEF0;
        rd_idx_a = 5; rd_sp_sel_a = 0; rd_size_a = 3; rd_signed_a = 0;
        #1 check("R2 read-before-write", rd_data_a, m_reg[5]);
        @(negedge clk); wr_en = 0; m_reg[5] = 64'h1234_5678_9ABC_DEF0;
        #1 check("R2 written value", rd_data_a, m_reg[5]);

        // R3: narrow writes with dirty upper halves.
        for (int i = 0; i < 31; i += 3) op(1, i, 0, 1, pat(i, 7) | 64'hFFFF_0000_0000_0000, 0, 0);
        op(1, 31, 1, 1, 64'hDEAD_BEEF_8000_0001, 0, 0);
        verify_all("R3 narrow writes");

        // R5: writes to index 31 with the select clear are dropped.
        op(1, 31, 0, 0, 64'hCAFE_F00D_CAFE_F00D, 0, 0);
        op(1, 31, 0, 1, 64'h0BAD_0BAD_0BAD_0BAD, 0, 0);
        verify_all("R5 R4 dropped alias write");

        // R6: stack pointer full write, read through both selects.
        op(1, 31, 1, 0, 64'h8000_0000_0000_0080, 0, 0);
        verify_all("R6 stack pointer");

        // R8: link save alone.
        op(0, 0, 0, 0, 0, 1, 64'h0000_4000_0000_1004);
        verify_all("R8 link save");

        // R9: link save collides with a write to 30, then with a write to 7.
        op(1, 30, 0, 0, 64'h5555_5555_5555_5555, 1, 64'h0000_0000_0040_2008);
        verify_all("R9 link priority");
        op(1, 7, 0, 0, 64'h7777_0000_7777_0000, 1, 64'h0000_0000_0040_3000);
        verify_all("R9 link plus other write");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule